// File: doc/BRIEF.md
# Mailbox Send-Side Register Block

A memory-mapped block that lets a local core post 64-bit messages to one of eight remote target cores. Software writes the low data word, the high data word and the target number, then writes the launch register. If the chosen target is idle, the block emits the message on its outgoing port for one cycle. It then marks the target busy and delivered. If the target still holds an unfetched message, the new message is dropped and the target's overflow flag is set. The remote side returns a per-target fetched strobe that releases busy.

All three per-target flag vectors share one status word. Software acknowledges delivered and overflow flags by writing the reported bits back to a separate clear register. A three-source interrupt covers busy, overflow and delivery. Each source has a mask bit. A sticky pending bit, cleared by software, drives the interrupt line.

Top module: `mbox_send_regs`

## Requirements
- R1: After reset the status word (0x14) reads 0, the mask (0x1C) reads 0x7, the interrupt status (0x18) reads 0, `irq_o` is low, and the target (0x00), low word (0x04) and high word (0x08) registers read 0.
- R2: Writes to 0x00 (target number, bits 2:0), 0x04 (low word) and 0x08 (high word) read back at the same offsets.
- R3: A write to 0x0C with bit 0 set, to an idle target, raises `tx_valid_o` during that write cycle, with `tx_target_o` equal to the target register and `tx_data_o` = {high word, low word}. A write to 0x0C with bit 0 clear has no effect.
- R4: After an accepted launch to target n, status bit n (busy) and bit 16+n (delivered) read 1.
- R5: A pulse on `fetch_i[n]` clears busy bit n. The delivered bit stays set.
- R6: A launch to a target whose busy bit is set raises no `tx_valid_o`, sets status bit 8+n (overflow), and leaves busy and delivered unchanged.
- R7: A write to 0x10 clears exactly the delivered flags selected by bits 23:16 and the overflow flags selected by bits 15:8. Bits 7:0 of that write are ignored, so busy flags are unaffected.
- R8: Mask register 0x1C gates the interrupt sources: bit 0 is any busy flag, bit 1 is any overflow flag, bit 2 is any delivered flag. A 1 disables that source.
- R9: The pending bit (0x18 bit 0, driven on `irq_o`) sets in the cycle after any unmasked source is active. Writing 1 to 0x18 bit 0 clears it only when no unmasked source is active.
- R10: Reads of 0x0C, 0x10 and any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| fetch_i | input | 8 | Per-target fetched strobe from the remote side |
| tx_valid_o | output | 1 | Message launch strobe |
| tx_target_o | output | 3 | Target of launched message |
| tx_data_o | output | 64 | Launched message {high, low} |
| irq_o | output | 1 | Interrupt line |

## Verification
Messages go to an idle target, to a busy target, and to a second target while the first still holds flags. These cases separate an accepted send from a dropped one, and show that flags stay per target. Clear writes use mixed delivered, overflow and busy bits, which shows that only the selected flags fall. Each interrupt source is unmasked on its own while the others stay masked. This ties each mask bit to its source and shows that the pending bit stays set while its source is still active.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int OFF_ID   = 'h00;
  localparam int OFF_LO   = 'h04;
  localparam int OFF_HI   = 'h08;
  localparam int OFF_TRIG = 'h0C;
  localparam int OFF_CLR  = 'h10;
  localparam int OFF_STS  = 'h14;
  localparam int OFF_IRQ  = 'h18;
  localparam int OFF_MSK  = 'h1C;
  // status word field bases
  localparam int STS_BUSY = 0;
  localparam int STS_OVF  = 8;
  localparam int STS_DLV  = 16;
  localparam int NSRC     = 3;
endpackage

// File: rtl/mbox_chan_flags.sv
module mbox_chan_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic fetch_i,
  input  logic clr_dlv_i,
  input  logic clr_ovf_i,
  output logic accept_o,
  output logic busy_o,
  output logic dlv_o,
  output logic ovf_o
);
  logic busy_q, dlv_q, ovf_q;

  assign accept_o = launch_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dlv_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (accept_o)     busy_q <= 1'b1;
      else if (fetch_i) busy_q <= 1'b0;
      if (accept_o)       dlv_q <= 1'b1;
      else if (clr_dlv_i) dlv_q <= 1'b0;
      if (launch_i && busy_q) ovf_q <= 1'b1;
      else if (clr_ovf_i)     ovf_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign dlv_o  = dlv_q;
  assign ovf_o  = ovf_q;

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (busy_o && dlv_o)); // R4
  AST_FETCH_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && !launch_i) |=> !busy_o); // R5
  AST_DROP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && busy_o) |=> ovf_o); // R6
  AST_CLR_IGNORES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fetch_i) |=> busy_o); // R7
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            msk_we_i,
  input  logic [NSRC-1:0] msk_wdata_i,
  input  logic            pend_clr_i,
  output logic [NSRC-1:0] msk_o,
  output logic            pend_o
);
  logic [NSRC-1:0] msk_q;
  logic            pend_q, act;

  assign act = |(src_i & ~msk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msk_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      if (msk_we_i) msk_q <= msk_wdata_i;
      pend_q <= act | (pend_q & ~pend_clr_i);
    end
  end

  assign msk_o  = msk_q;
  assign pend_o = pend_q;

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !pend_clr_i) |=> pend_o); // R9
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_o && (src_i & ~msk_o) == '0) |=> !pend_o); // R8
endmodule

// File: rtl/mbox_send_regs.sv
module mbox_send_regs
  import mbox_pkg::*;
#(
  parameter int N_TGT = 8,
  parameter int AW    = 6,
  parameter int DW    = 32,
  localparam int TW   = $clog2(N_TGT)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [N_TGT-1:0] fetch_i,
  output logic            tx_valid_o,
  output logic [TW-1:0]   tx_target_o,
  output logic [2*DW-1:0] tx_data_o,
  output logic            irq_o
);
  logic            wr, rd;
  logic [TW-1:0]   id_q;
  logic [DW-1:0]   lo_q, hi_q;
  logic            trig, clr_wr;
  logic [N_TGT-1:0] accept, busy, dlv, ovf;
  logic [NSRC-1:0] msk;
  logic            pend;
  logic [DW-1:0]   sts;

  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign trig   = wr && addr_i == AW'(OFF_TRIG) && wdata_i[0];
  assign clr_wr = wr && addr_i == AW'(OFF_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr) begin
      if (addr_i == AW'(OFF_ID)) id_q <= wdata_i[TW-1:0];
      if (addr_i == AW'(OFF_LO)) lo_q <= wdata_i;
      if (addr_i == AW'(OFF_HI)) hi_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < N_TGT; g++) begin : g_chan
    mbox_chan_flags u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .launch_i (trig && id_q == TW'(g)),
      .fetch_i  (fetch_i[g]),
      .clr_dlv_i(clr_wr & wdata_i[STS_DLV+g]),
      .clr_ovf_i(clr_wr & wdata_i[STS_OVF+g]),
      .accept_o (accept[g]),
      .busy_o   (busy[g]),
      .dlv_o    (dlv[g]),
      .ovf_o    (ovf[g])
    );
  end

  mbox_irq_ctrl u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      ({|dlv, |ovf, |busy}),
    .msk_we_i   (wr && addr_i == AW'(OFF_MSK)),
    .msk_wdata_i(wdata_i[NSRC-1:0]),
    .pend_clr_i (wr && addr_i == AW'(OFF_IRQ) && wdata_i[0]),
    .msk_o      (msk),
    .pend_o     (pend)
  );

  assign sts = (DW'(dlv) << STS_DLV) | (DW'(ovf) << STS_OVF) | (DW'(busy) << STS_BUSY);

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        AW'(OFF_ID):  rdata_o = DW'(id_q);
        AW'(OFF_LO):  rdata_o = lo_q;
        AW'(OFF_HI):  rdata_o = hi_q;
        AW'(OFF_STS): rdata_o = sts;
        AW'(OFF_IRQ): rdata_o = DW'(pend);
        AW'(OFF_MSK): rdata_o = DW'(msk);
        default:      rdata_o = '0;
      endcase
    end
  end

  assign tx_valid_o  = |accept;
  assign tx_target_o = id_q;
  assign tx_data_o   = {hi_q, lo_q};
  assign irq_o       = pend;

  AST_TX_NEEDS_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (req_i && we_i && wdata_i[0])); // R3
  AST_TX_ONE_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(accept)); // R3
  AST_TX_MARKS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> busy[$past(tx_target_o)]); // R4
endmodule

// File: tb/sim_mbox_send_regs.sv
module sim_mbox_send_regs;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  fetch = '0;
  logic        tx_valid, irq;
  logic [2:0]  tx_target;
  logic [63:0] tx_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct packed { logic [2:0] t; logic [63:0] d; } item_t;
  item_t exp_q[$];

  always #(CLK_NS/2) clk = ~clk;

  mbox_send_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .fetch_i(fetch), .tx_valid_o(tx_valid),
    .tx_target_o(tx_target), .tx_data_o(tx_data), .irq_o(irq)
  );

  task automatic chk(string r, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on each launch
  always @(negedge clk) if (rst_n && tx_valid) begin
    item_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R6 unexpected launch actual=%h/%h expected=none", tx_target, tx_data);
    end else begin
      e = exp_q.pop_front();
      if (e.t !== tx_target || e.d !== tx_data) begin
        n_fail++;
        $display("FAIL R3 launch actual=%h/%h expected=%h/%h", tx_target, tx_data, e.t, e.d);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #2 req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    @(posedge clk); #2 req = 0; we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(posedge clk); #2 req = 1; we = 0; addr = a;
    @(negedge clk); d = rdata;
    @(posedge clk); #2 req = 0;
  endtask

  task automatic rchk(string r, logic [5:0] a, logic [31:0] e);
    logic [31:0] v;
    rd(a, v);
    chk(r, 64'(v), 64'(e));
  endtask

  // driver: a send that the requirements say is accepted pushes an item
  task automatic send(logic [2:0] t, logic [31:0] lo, logic [31:0] hi, bit accepted);
    wr(6'h04, lo); wr(6'h08, hi); wr(6'h00, 32'(t));
    if (accepted) exp_q.push_back({t, hi, lo});
    wr(6'h0C, 32'h1);
  endtask

  task automatic pulse_fetch(logic [7:0] m);
    @(posedge clk); #2 fetch = m;
    @(posedge clk); #2 fetch = '0;
  endtask

  initial begin
    #(CLK_NS * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1
    rchk("R1 status", 6'h14, 0);
    rchk("R1 mask", 6'h1C, 32'h7);
    rchk("R1 irq sts", 6'h18, 0);
    rchk("R1 id", 6'h00, 0);
    rchk("R1 lo", 6'h04, 0);
    rchk("R1 hi", 6'h08, 0);
    chk("R1 irq_o", 64'(irq), 0);
    // R2
    wr(6'h00, 32'h3); wr(6'h04, 32'hA5A5_0001); wr(6'h08, 32'h5A5A_0002);
    rchk("R2 id", 6'h00, 32'h3);
    rchk("R2 lo", 6'h04, 32'hA5A5_0001);
    rchk("R2 hi", 6'h08, 32'h5A5A_0002);
    // R3 trigger with bit0 clear does nothing
    wr(6'h0C, 32'h2);
    rchk("R3 no launch", 6'h14, 0);
    // R3/R4 accepted send to target 3
    send(3'd3, 32'h1111_2222, 32'h3333_4444, 1);
    rchk("R4 busy+dlv", 6'h14, 32'h0008_0008);
    // R6 second send to busy target 3 is dropped
    send(3'd3, 32'hDEAD_0000, 32'hBEEF_0000, 0);
    rchk("R6 overflow", 6'h14, 32'h0008_0808);
    // R5 fetch releases busy only
    pulse_fetch(8'h08);
    rchk("R5 fetch", 6'h14, 32'h0008_0800);
    // second target
    send(3'd5, 32'h0000_5555, 32'h6666_0000, 1);
    rchk("R4 target5", 6'h14, 32'h0028_0820);
    // R7 selective clear, busy bits in write ignored
    wr(6'h10, 32'h0008_08FF);
    rchk("R7 clear", 6'h14, 32'h0020_0020);
    // R10
    rchk("R10 trig read", 6'h0C, 0);
    rchk("R10 clr read", 6'h10, 0);
    rchk("R10 unmapped", 6'h24, 0);
    // R8/R9 delivery source
    chk("R8 all masked", 64'(irq), 0);
    wr(6'h1C, 32'h3);
    rchk("R9 dlv pending", 6'h18, 32'h1);
    chk("R9 irq_o", 64'(irq), 1);
    wr(6'h18, 32'h1);
    rchk("R9 clear while active", 6'h18, 32'h1);
    wr(6'h1C, 32'h7); wr(6'h18, 32'h1);
    rchk("R9 clear idle", 6'h18, 0);
    chk("R9 irq_o low", 64'(irq), 0);
    // R8 overflow source
    wr(6'h1C, 32'h5);
    rchk("R8 ovf quiet", 6'h18, 0);
    send(3'd5, 32'h7, 32'h8, 0);
    rchk("R8 ovf pending", 6'h18, 32'h1);
    rchk("R6 ovf5", 6'h14, 32'h0020_2020);
    // R8 busy source
    wr(6'h10, 32'h00FF_FF00); wr(6'h1C, 32'h7); wr(6'h18, 32'h1);
    rchk("R7 cleared", 6'h14, 32'h0000_0020);
    rchk("R9 quiet", 6'h18, 0);
    wr(6'h1C, 32'h6);
    rchk("R8 busy pending", 6'h18, 32'h1);
    pulse_fetch(8'h20); wr(6'h18, 32'h1);
    rchk("R5 busy gone irq clear", 6'h18, 0);
    rchk("R5 status", 6'h14, 0);
    repeat (2) @(posedge clk);
    chk("R3 all launches seen", 64'(exp_q.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule